// File: doc/BRIEF.md
# Interrupt State and Priority Selector

This block keeps the lifecycle state of every interrupt in a small interrupt controller and offers one CPU interface the most urgent interrupt that may be taken. Ids 0 to 15 are software-generated, ids 16 to 31 are private to the CPU, and a parameterised number of shared interrupts follows them. The total never exceeds 1020 ids.

Each interrupt holds an enable bit, a pending bit, an active bit, a trigger mode (level or edge), an 8-bit priority and an 8-bit target field. The pending and active bits together give four states: inactive, pending, active, and active-and-pending. Hardware lines raise interrupts. One command per cycle on a small control port changes one interrupt. The CPU side uses an acknowledge strobe for the presented id and an end-of-interrupt strobe carrying an id. A read port shows the stored state of any single id.

Top module: `irq_selector`

## Requirements
- R1: After reset every interrupt is disabled, not pending, not active, level-triggered, at priority 0, with target 1.
- R2: An interrupt is presented only when it is enabled, pending and not active. `sel_valid` is high exactly when at least one such interrupt exists.
- R3: When no interrupt qualifies, `sel_valid` is low and `sel_id` reads 1023.
- R4: Among qualifying interrupts, the one with the numerically lowest priority value is presented. On equal priority, the lower id is presented.
- R5: A command with `cmd_valid` high acts on `cmd_id` using these `cmd_op` codes:
  - 0 enables the interrupt, and 1 disables it.
  - 2 sets pending, and 3 clears pending.
  - 4 sets active, and 5 clears active.
  - 6 writes the priority from `cmd_data`.
  - 7 writes the target from `cmd_data`.
  - 8 writes the trigger mode from `cmd_data[0]` (1 = edge, 0 = level).
- R6: `ack` while `sel_valid` is high makes the presented interrupt active. It leaves the interrupt not pending, unless the interrupt is level-triggered and its line is still high, in which case it stays pending.
- R7: End-of-interrupt clears the active bit of `eoi_id`. A level-triggered interrupt whose line is still high is pending afterwards.
- R8: An edge-triggered interrupt becomes pending on a rising edge of its line, including while it is active (giving active-and-pending). A falling line does not clear it.
- R9: A level-triggered interrupt is pending while its line is high, and its pending bit clears when the line falls.
- R10: Every input is sampled on a rising clock edge. State, read port and selection all reflect it directly after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32+NUM_SHARED | Hardware interrupt lines, one per id |
| cmd_valid | input | 1 | Control command strobe |
| cmd_op | input | 4 | Command code (see R5) |
| cmd_id | input | 10 | Target interrupt of the command |
| cmd_data | input | 8 | Priority, target or mode value |
| ack | input | 1 | Acknowledge the presented interrupt |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | Interrupt being completed |
| qry_id | input | 10 | Id shown on the read port |
| sel_valid | output | 1 | A qualifying interrupt is presented |
| sel_id | output | 10 | Presented id, or 1023 |
| qry_enabled | output | 1 | Enable bit of qry_id |
| qry_pending | output | 1 | Pending bit of qry_id |
| qry_active | output | 1 | Active bit of qry_id |
| qry_edge | output | 1 | Trigger mode of qry_id (1 = edge) |
| qry_prio | output | 8 | Priority of qry_id |
| qry_target | output | 8 | Target field of qry_id |

## Verification
The checker tests the following on every cycle:
- The presented id is a qualifying interrupt.
- No qualifying interrupt has a better priority than the presented one.
- No qualifying interrupt is missed when the output shows 1023.
- Acknowledge always leaves the presented id active.
- End-of-interrupt always leaves its id inactive.

The bench scenarios cover what depends on specific histories. These are the reset contents, the tie between equal priorities, the effect of the lines on pending in each trigger mode, and the active-and-pending case for an edge-triggered interrupt.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [3:0] {
        OP_ENABLE     = 4'd0,
        OP_DISABLE    = 4'd1,
        OP_SET_PEND   = 4'd2,
        OP_CLR_PEND   = 4'd3,
        OP_SET_ACT    = 4'd4,
        OP_CLR_ACT    = 4'd5,
        OP_WR_PRIO    = 4'd6,
        OP_WR_TARGET  = 4'd7,
        OP_WR_TRIGGER = 4'd8
    } irq_op_e;

    typedef struct packed {
        logic       en;
        logic       pend;
        logic       act;
        logic       edge_cfg;
        logic [7:0] prio;
        logic [7:0] tgt;
    } irq_rec_t;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } sel_t;
endpackage

// File: rtl/irqsel_state.sv
module irqsel_state
    import irqsel_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  lines,
    input  logic                cmd_valid,
    input  irq_op_e             cmd_op,
    input  logic [ID_W-1:0]     cmd_id,
    input  logic [7:0]          cmd_data,
    input  logic                ack_fire,
    input  logic [ID_W-1:0]     ack_id,
    input  logic                eoi_valid,
    input  logic [ID_W-1:0]     eoi_id,
    output irq_rec_t            rec_d [NUM_IRQ],
    output irq_rec_t            rec_q [NUM_IRQ]
);
    logic [NUM_IRQ-1:0] line_q;
    logic [NUM_IRQ-1:0] line_d;

    always_comb begin
        irq_rec_t r;
        line_d = lines;
        for (int i = 0; i < NUM_IRQ; i++) begin
            r = rec_q[i];
            // line events first, by trigger mode
            if (r.edge_cfg) begin
                if (lines[i] && !line_q[i]) r.pend = 1'b1;
            end else begin
                if (lines[i]) r.pend = 1'b1;
                else if (line_q[i]) r.pend = 1'b0;
            end
            // control command
            if (cmd_valid && cmd_id == ID_W'(i)) begin
                case (cmd_op)
                    OP_ENABLE:     r.en       = 1'b1;
                    OP_DISABLE:    r.en       = 1'b0;
                    OP_SET_PEND:   r.pend     = 1'b1;
                    OP_CLR_PEND:   r.pend     = 1'b0;
                    OP_SET_ACT:    r.act      = 1'b1;
                    OP_CLR_ACT:    r.act      = 1'b0;
                    OP_WR_PRIO:    r.prio     = cmd_data;
                    OP_WR_TARGET:  r.tgt      = cmd_data;
                    OP_WR_TRIGGER: r.edge_cfg = cmd_data[0];
                    default: ;
                endcase
            end
            // acknowledge: take the interrupt
            if (ack_fire && ack_id == ID_W'(i)) begin
                r.act  = 1'b1;
                r.pend = !r.edge_cfg && lines[i];
            end
            // completion last so it always wins on the active bit
            if (eoi_valid && eoi_id == ID_W'(i)) r.act = 1'b0;
            rec_d[i] = r;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            for (int i = 0; i < NUM_IRQ; i++)
                rec_q[i] <= '{en: 1'b0, pend: 1'b0, act: 1'b0, edge_cfg: 1'b0,
                              prio: 8'd0, tgt: 8'd1};
        end else begin
            line_q <= line_d;
            for (int i = 0; i < NUM_IRQ; i++) rec_q[i] <= rec_d[i];
        end
    end
endmodule

// File: rtl/irqsel_pick.sv
module irqsel_pick
    import irqsel_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  irq_rec_t        rec [NUM_IRQ],
    output logic            found,
    output logic [ID_W-1:0] id
);
    logic [7:0] best_prio;

    always_comb begin
        found     = 1'b0;
        id        = SPURIOUS_ID;
        best_prio = 8'hFF;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (rec[i].en && rec[i].pend && !rec[i].act &&
                (!found || rec[i].prio < best_prio)) begin
                found     = 1'b1;
                id        = ID_W'(i);
                best_prio = rec[i].prio;
            end
        end
    end
endmodule

// File: rtl/irq_selector.sv
module irq_selector
    import irqsel_pkg::*;
#(
    parameter int NUM_SHARED = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [32+NUM_SHARED-1:0] irq_lines,
    input  logic                   cmd_valid,
    input  logic [3:0]             cmd_op,
    input  logic [9:0]             cmd_id,
    input  logic [7:0]             cmd_data,
    input  logic                   ack,
    input  logic                   eoi_valid,
    input  logic [9:0]             eoi_id,
    input  logic [9:0]             qry_id,
    output logic                   sel_valid,
    output logic [9:0]             sel_id,
    output logic                   qry_enabled,
    output logic                   qry_pending,
    output logic                   qry_active,
    output logic                   qry_edge,
    output logic [7:0]             qry_prio,
    output logic [7:0]             qry_target
);
    localparam int NUM_IRQ = 32 + NUM_SHARED;
    localparam int IDX_W   = $clog2(NUM_IRQ);

    irq_rec_t rec_d [NUM_IRQ];
    irq_rec_t rec_q [NUM_IRQ];
    sel_t     sel_d, sel_q;
    logic     pick_found;
    logic [ID_W-1:0] pick_id;
    logic     ack_fire;
    irq_rec_t qry_rec;

    assign ack_fire = ack && sel_q.valid;

    irqsel_state #(.NUM_IRQ(NUM_IRQ)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (irq_lines),
        .cmd_valid(cmd_valid),
        .cmd_op   (irq_op_e'(cmd_op)),
        .cmd_id   (cmd_id),
        .cmd_data (cmd_data),
        .ack_fire (ack_fire),
        .ack_id   (sel_q.id),
        .eoi_valid(eoi_valid),
        .eoi_id   (eoi_id),
        .rec_d    (rec_d),
        .rec_q    (rec_q)
    );

    // selection looks at next state so it lands on the same edge
    irqsel_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
        .rec  (rec_d),
        .found(pick_found),
        .id   (pick_id)
    );

    always_comb begin
        sel_d.valid = pick_found;
        sel_d.id    = pick_found ? pick_id : SPURIOUS_ID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '{valid: 1'b0, id: SPURIOUS_ID};
        else        sel_q <= sel_d;
    end

    assign sel_valid = sel_q.valid;
    assign sel_id    = sel_q.id;

    always_comb begin
        qry_rec = '0;
        if (qry_id < ID_W'(NUM_IRQ)) qry_rec = rec_q[qry_id[IDX_W-1:0]];
    end

    assign qry_enabled = qry_rec.en;
    assign qry_pending = qry_rec.pend;
    assign qry_active  = qry_rec.act;
    assign qry_edge    = qry_rec.edge_cfg;
    assign qry_prio    = qry_rec.prio;
    assign qry_target  = qry_rec.tgt;
endmodule

// File: rtl/irqsel_checker.sv
module irqsel_checker
    import irqsel_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack,
    input logic            eoi_valid,
    input logic [ID_W-1:0] eoi_id,
    input logic            sel_valid,
    input logic [ID_W-1:0] sel_id,
    input irq_rec_t        rec_q [NUM_IRQ]
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    logic [IDX_W-1:0] sel_idx, eoi_idx;
    assign sel_idx = sel_id[IDX_W-1:0];
    assign eoi_idx = eoi_id[IDX_W-1:0];

    assert_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> sel_id == SPURIOUS_ID);

    assert_sel_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (rec_q[sel_idx].en && rec_q[sel_idx].pend && !rec_q[sel_idx].act));

    assert_ack_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && sel_valid && !(eoi_valid && eoi_id == sel_id)) |=> rec_q[$past(sel_idx)].act);

    assert_eoi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_id < ID_W'(NUM_IRQ)) |=> !rec_q[$past(eoi_idx)].act);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_each
        logic cand;
        assign cand = rec_q[g].en && rec_q[g].pend && !rec_q[g].act;

        assert_prio_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_valid && cand) |-> (rec_q[sel_idx].prio < rec_q[g].prio ||
                (rec_q[sel_idx].prio == rec_q[g].prio && sel_id <= ID_W'(g))));

        assert_none_missed_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_valid |-> !cand);
    end
endmodule

bind irq_selector irqsel_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .eoi_valid(eoi_valid),
    .eoi_id   (eoi_id),
    .sel_valid(sel_valid),
    .sel_id   (sel_id),
    .rec_q    (rec_q)
);

// File: tb/sim_irq_selector.sv
module sim_irq_selector;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_SHARED = 32;
    localparam int NUM_IRQ    = 32 + NUM_SHARED;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_IRQ-1:0] irq_lines = '0;
    logic               cmd_valid = 1'b0;
    logic [3:0]         cmd_op = '0;
    logic [9:0]         cmd_id = '0;
    logic [7:0]         cmd_data = '0;
    logic               ack = 1'b0;
    logic               eoi_valid = 1'b0;
    logic [9:0]         eoi_id = '0;
    logic [9:0]         qry_id = '0;
    logic               sel_valid;
    logic [9:0]         sel_id;
    logic               qry_enabled, qry_pending, qry_active, qry_edge;
    logic [7:0]         qry_prio, qry_target;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_selector #(.NUM_SHARED(NUM_SHARED)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_data(cmd_data),
        .ack(ack), .eoi_valid(eoi_valid), .eoi_id(eoi_id), .qry_id(qry_id),
        .sel_valid(sel_valid), .sel_id(sel_id),
        .qry_enabled(qry_enabled), .qry_pending(qry_pending), .qry_active(qry_active),
        .qry_edge(qry_edge), .qry_prio(qry_prio), .qry_target(qry_target)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic cmd(input int op, input int id, input int data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'(op); cmd_id = 10'(id); cmd_data = 8'(data);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_line(input int id, input logic v);
        @(negedge clk);
        irq_lines[id] = v;
        @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_eoi(input int id);
        @(negedge clk); eoi_valid = 1'b1; eoi_id = 10'(id);
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic look(input int id, output int st);
        qry_id = 10'(id); #1;
        st = {qry_enabled, qry_pending, qry_active};
    endtask

    task automatic t_reset();
        int st;
        look(40, st);
        chk("R1 state bits", st, 0);
        chk("R1 trigger level", int'(qry_edge), 0);
        chk("R1 priority", int'(qry_prio), 0);
        chk("R1 target", int'(qry_target), 1);
        chk("R3 valid low", int'(sel_valid), 0);
        chk("R3 spurious id", int'(sel_id), 1023);
    endtask

    task automatic t_config();
        int st;
        cmd(6, 40, 8'h5A);
        cmd(7, 40, 8'h03);
        cmd(8, 40, 1);
        look(40, st);
        chk("R5 prio write", int'(qry_prio), 8'h5A);
        chk("R5 target write", int'(qry_target), 3);
        chk("R5 edge write", int'(qry_edge), 1);
        cmd(8, 40, 0);
        look(40, st);
        chk("R5 level write", int'(qry_edge), 0);
    endtask

    task automatic t_gate();
        int st;
        cmd(2, 20, 0);
        look(20, st);
        chk("R5 set pending", st, 3'b010);
        chk("R2 disabled not shown", int'(sel_valid), 0);
        cmd(0, 20, 0);
        chk("R2 enabled shown", int'(sel_valid), 1);
        chk("R10 same-edge select", int'(sel_id), 20);
    endtask

    task automatic t_arb();
        cmd(6, 20, 8'h40);
        cmd(6, 35, 8'h10); cmd(0, 35, 0); cmd(2, 35, 0);
        cmd(6, 50, 8'h10); cmd(0, 50, 0); cmd(2, 50, 0);
        chk("R4 tie lower id", int'(sel_id), 35);
        cmd(6, 50, 8'h08);
        chk("R4 lower value wins", int'(sel_id), 50);
        cmd(6, 50, 8'h10);
        chk("R4 tie restored", int'(sel_id), 35);
    endtask

    task automatic t_edge();
        int st;
        cmd(8, 35, 1);
        do_ack();
        look(35, st);
        chk("R6 edge ack to active", st, 3'b101);
        chk("R2 active not shown", int'(sel_id), 50);
        set_line(35, 1'b1);
        look(35, st);
        chk("R8 active and pending", st, 3'b111);
        set_line(35, 1'b0);
        look(35, st);
        chk("R8 fall keeps pending", st, 3'b111);
        chk("R2 active-pending not shown", int'(sel_id), 50);
        do_eoi(35);
        look(35, st);
        chk("R7 eoi clears active", st, 3'b110);
        chk("R7 returns to selection", int'(sel_id), 35);
    endtask

    task automatic t_level();
        int st;
        cmd(0, 60, 0);
        set_line(60, 1'b1);
        look(60, st);
        chk("R9 level line pends", st, 3'b110);
        chk("R4 prio 0 wins", int'(sel_id), 60);
        do_ack();
        look(60, st);
        chk("R6 level ack stays pending", st, 3'b111);
        chk("R6 selection moves on", int'(sel_id), 35);
        do_eoi(60);
        look(60, st);
        chk("R7 level repend", st, 3'b110);
        chk("R7 level reselected", int'(sel_id), 60);
        set_line(60, 1'b0);
        look(60, st);
        chk("R9 line fall clears", st, 3'b100);
        chk("R9 selection after fall", int'(sel_id), 35);
    endtask

    task automatic t_clear();
        int st;
        cmd(4, 50, 0);
        look(50, st);
        chk("R5 set active", st, 3'b111);
        cmd(5, 50, 0);
        look(50, st);
        chk("R5 clear active", st, 3'b110);
        cmd(1, 35, 0);
        look(35, st);
        chk("R5 disable", st, 3'b010);
        cmd(3, 50, 0); cmd(3, 20, 0);
        look(50, st);
        chk("R5 clear pending", st, 3'b100);
        chk("R3 nothing qualifies", int'(sel_valid), 0);
        chk("R3 spurious again", int'(sel_id), 1023);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_gate();
        t_arb();
        t_edge();
        t_level();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule